// File: doc/BRIEF.md
# SDRAM refresh interval timer

This block tells an SDRAM sequencer when a refresh is due. A two-bit rate code picks one of three refresh periods or switches refresh off. A two-bit clock code says which of three bus clock rates the core runs at. From these two codes the block derives the period in cycles, counts it down and raises a refresh request each time the period runs out. The request stays high until the sequencer acknowledges it.

The period is measured from the moment a request is issued, not from when it is served. If the sequencer falls behind, later expiries are kept in a saturating count of owed refreshes. Each acknowledge then retires one owed refresh while the request stays up, so a slow sequencer can catch up. Any change of either code restarts the period. Setting the rate code to zero drops all outstanding work at once.

Top module: `sdram_refresh_timer`

## Requirements
- R1: During and right after reset, `ref_req` is 0 and `owed` is 0.
- R2: While `rate_sel` is 00, no request is ever raised.
- R3: The period in cycles is floor(MHz x ns / 1000). `freq_sel` 0, 1 and 2 select 66, 100 and 133 MHz. `rate_sel` 01, 10 and 11 select 7800 ns, 15600 ns and 125000 ns. This gives 514/1029/8250 cycles at 66 MHz, 780/1560/12500 at 100 MHz and 1037/2074/16625 at 133 MHz. `ref_req` rises on the N-th clock edge after the edge that loads the period.
- R4: `freq_sel` 3 uses the 66 MHz counts, so the period can never exceed its nominal length.
- R5: Once raised, `ref_req` stays high until `ref_ack` is seen. An acknowledge with `owed` at 0 drops `ref_req` one cycle later.
- R6: Expiries follow one another every N cycles from the issue of the request, whenever the acknowledge comes.
- R7: An expiry while `ref_req` is high adds one to `owed`. `owed` saturates at 8.
- R8: An acknowledge while `owed` is above 0 lowers `owed` by one and keeps `ref_req` high.
- R9: `ref_ack` while `ref_req` is low has no effect.
- R10: A change of `rate_sel` or `freq_sel` to a nonzero rate reloads the period counter. Pending requests and `owed` are kept.
- R11: Setting `rate_sel` to 00 clears `ref_req` and `owed` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, equal to the bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Refresh period code: 00 off, 01/10/11 short/medium/long |
| freq_sel | input | 2 | Bus clock code: 0=66, 1=100, 2=133 MHz, 3 as 0 |
| ref_ack | input | 1 | Sequencer has carried out one refresh |
| ref_req | output | 1 | A refresh is due |
| owed | output | 4 | Refreshes owed beyond the one requested, 0 to 8 |

## Verification
The embedded properties watch, on every cycle, the local rules of the request. They check that the request holds without an acknowledge, that it drops on a final acknowledge and that it never rises without an expiry. They also check that the owed count stays within its limit and saturates, and that the off code clears everything. The exact number of cycles in each of the nine periods cannot be seen this way. Neither can the restart on a code change, or the timing from issue rather than from acknowledge. Only the bench scenarios show these, by comparing request edges against cycle numbers it computes itself.

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int unsigned F0_MHZ   = 66,
  parameter int unsigned F1_MHZ   = 100,
  parameter int unsigned F2_MHZ   = 133,
  parameter int unsigned SHORT_NS = 7800,
  parameter int unsigned MID_NS   = 15600,
  parameter int unsigned LONG_NS  = 125000,
  parameter int unsigned OWED_MAX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic [1:0] freq_sel,
  input  logic       ref_ack,
  output logic       ref_req,
  output logic [$clog2(OWED_MAX+1)-1:0] owed
);
  localparam int unsigned FMAX  = (F0_MHZ > F1_MHZ) ? ((F0_MHZ > F2_MHZ) ? F0_MHZ : F2_MHZ)
                                                    : ((F1_MHZ > F2_MHZ) ? F1_MHZ : F2_MHZ);
  localparam int unsigned NMAX  = (SHORT_NS > MID_NS) ? ((SHORT_NS > LONG_NS) ? SHORT_NS : LONG_NS)
                                                      : ((MID_NS > LONG_NS) ? MID_NS : LONG_NS);
  localparam int unsigned MAXC  = FMAX * NMAX / 1000;
  localparam int          CW    = $clog2(MAXC + 1);
  localparam int          OW    = $clog2(OWED_MAX + 1);
  localparam int unsigned MHZ [4] = '{F0_MHZ, F1_MHZ, F2_MHZ, F0_MHZ};
  localparam int unsigned NSV [4] = '{0, SHORT_NS, MID_NS, LONG_NS};

  logic [CW-1:0] tbl [16];
  for (genvar fi = 0; fi < 4; fi++) begin : g_freq
    for (genvar ri = 0; ri < 4; ri++) begin : g_rate
      assign tbl[fi*4+ri] = CW'(MHZ[fi] * NSV[ri] / 1000);
    end
  end

  logic [CW-1:0] cnt;
  logic [1:0]    rate_q, freq_q;
  wire  [CW-1:0] intv   = tbl[{freq_sel, rate_sel}];
  wire           active = (rate_sel != 2'b00);
  wire           reload = (rate_sel != rate_q) || (freq_sel != freq_q);
  wire           expire = active && !reload && (cnt == '0);
  wire           take   = ref_req && ref_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rate_q  <= 2'b00;
      freq_q  <= 2'b00;
      ref_req <= 1'b0;
      owed    <= '0;
    end else begin
      rate_q <= rate_sel;
      freq_q <= freq_sel;
      if (!active) begin
        cnt     <= '0;
        ref_req <= 1'b0;
        owed    <= '0;
      end else begin
        cnt <= (reload || expire) ? intv - CW'(1) : cnt - CW'(1);
        case ({expire, take})
          2'b10: begin
            if (!ref_req) ref_req <= 1'b1;
            else if (owed != OW'(OWED_MAX)) owed <= owed + OW'(1);
          end
          2'b01: begin
            if (owed != '0) owed <= owed - OW'(1);
            else ref_req <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_OWED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(OWED_MAX)); // R7
  AST_IDLE_NO_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_req |-> owed == '0); // R7
  AST_OWED_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == OW'(OWED_MAX) && !ref_ack && active) |=> owed == OW'(OWED_MAX)); // R7
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'b00) |=> (!ref_req && owed == '0)); // R11
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack && active) |=> ref_req); // R5
  AST_LAST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack && owed == '0 && !expire && active) |=> !ref_req); // R5
  AST_NO_SPONTANEOUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_req && !expire) |=> !ref_req); // R9
endmodule

// File: tb/sim_sdram_refresh_timer.sv
module sim_sdram_refresh_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic [1:0] freq_sel = 2'd1;
  logic       ref_ack = 1'b0;
  logic       ref_req;
  logic [3:0] owed;

  sdram_refresh_timer u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .freq_sel(freq_sel),
    .ref_ack(ref_ack), .ref_req(ref_req), .owed(owed)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    when;
    bit    req;
    int    owe;
    string tag;
  } item_t;

  item_t q[$];
  item_t it;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  task automatic push(int when, bit r, int o, string tag);
    item_t x;
    x.when = when; x.req = r; x.owe = o; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic step_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].when <= cyc) begin
      it = q.pop_front();
      compared++;
      if (it.when < cyc) begin
        mismatched++;
        $display("FAIL %s: sample at cycle %0d missed, now %0d (actual req=%0b owed=%0d, expected req=%0b owed=%0d)",
                 it.tag, it.when, cyc, ref_req, owed, it.req, it.owe);
      end else if (ref_req !== it.req || int'(owed) != it.owe) begin
        mismatched++;
        $display("FAIL %s at cycle %0d: actual req=%0b owed=%0d, expected req=%0b owed=%0d",
                 it.tag, cyc, ref_req, owed, it.req, it.owe);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual cycle=%0d, expected end before 200000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  int fs [7] = '{0, 0, 1, 2, 2, 2, 3};
  int rs [7] = '{2, 3, 3, 1, 2, 3, 1};
  int ns [7] = '{1029, 8250, 12500, 1037, 2074, 16625, 514};

  initial begin
    int c, d, e, f, g;
    push(3, 0, 0, "R1 held in reset");
    step_to(5);
    rst_n = 1'b1;
    push(6, 0, 0, "R1 after reset");
    step_to(7);

    c = cyc;
    push(c + 1000, 0, 0, "R2 rate off stays idle");
    step_to(c + 1001);

    c = cyc;
    freq_sel = 2'd1; rate_sel = 2'b01;
    push(c + 780, 0, 0, "R3 100MHz short not yet");
    push(c + 781, 1, 0, "R3 100MHz short rises");
    push(c + 880, 1, 0, "R5 held without ack");
    push(c + 882, 0, 0, "R5 ack drops request");
    step_to(c + 881); ref_ack = 1'b1;
    step_to(c + 882); ref_ack = 1'b0;
    push(c + 1560, 0, 0, "R6 before next period");
    push(c + 1561, 1, 0, "R6 period from issue");
    push(c + 2341, 1, 1, "R7 owed one");
    push(c + 3121, 1, 2, "R7 owed two");
    push(c + 3201, 1, 1, "R8 ack retires owed");
    push(c + 3202, 1, 0, "R8 ack retires owed");
    push(c + 3203, 0, 0, "R5 last ack drops");
    step_to(c + 3200); ref_ack = 1'b1;
    step_to(c + 3203); ref_ack = 1'b0;
    push(c + 3501, 0, 0, "R9 idle ack ignored");
    push(c + 3900, 0, 0, "R9 timing unaffected");
    push(c + 3901, 1, 0, "R9 timing unaffected");
    step_to(c + 3500); ref_ack = 1'b1;
    step_to(c + 3501); ref_ack = 1'b0;
    step_to(c + 3910);

    d = cyc;
    freq_sel = 2'd0;
    push(d + 514, 1, 0, "R10 clock change reload keeps request");
    push(d + 515, 1, 1, "R10 66MHz period after reload");
    push(d + 1 + 514 * 8, 1, 8, "R7 owed reaches limit");
    push(d + 1 + 514 * 9, 1, 8, "R7 owed saturates");
    step_to(d + 1 + 514 * 9 + 5);

    e = cyc;
    rate_sel = 2'b00;
    push(e + 1, 0, 0, "R11 off clears all");
    push(e + 2000, 0, 0, "R2 off stays idle");
    step_to(e + 2001);

    f = cyc;
    freq_sel = 2'd1; rate_sel = 2'b01;
    step_to(f + 500);
    rate_sel = 2'b10;
    push(f + 781, 0, 0, "R10 old period abandoned");
    push(f + 500 + 1560, 0, 0, "R10 rate change reload");
    push(f + 501 + 1560, 1, 0, "R10 rate change reload");
    step_to(f + 501 + 1560 + 3);

    for (int i = 0; i < 7; i++) begin
      rate_sel = 2'b00;
      step_to(cyc + 2);
      g = cyc;
      freq_sel = fs[i][1:0]; rate_sel = rs[i][1:0];
      push(g + ns[i], 0, 0, (fs[i] == 3) ? "R4 code 3 as 66MHz" : "R3 table period");
      push(g + ns[i] + 1, 1, 0, (fs[i] == 3) ? "R4 code 3 as 66MHz" : "R3 table period");
      step_to(g + ns[i] + 3);
    end

    step_to(cyc + 5);
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: actual %0d items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule